// File: doc/BRIEF.md
# Square-Root Stage Sequencer with Result Interlock

This block steps a long-latency floating-point square root through its execution stages inside an in-order pipeline. It accepts an issue pulse with a precision bit and a destination register index. It then walks a fixed stage sequence, and that sequence depends on the precision. While the operation runs, the block keeps the destination register marked busy. The arithmetic itself is handled elsewhere. This block only orders the stages, detects hazards and raises the stall.

A single-precision operation spends 13 cycles from fetch to completion and a double-precision operation spends 26. Most of that time is spent in a run of iterative stages. These iterative stages advance every clock, whether or not the issuing pipeline is moving. The instruction that follows is described on a small side bus. It is held when it reads or writes the busy register, when it touches floating-point control state, or when it is itself another square root. Unrelated instructions are not held. In the final stage the block pulses a write-back carrying the destination index and releases the hold, so the dependent instruction proceeds on the next cycle.

Top module: `sqrt_seq_ctrl`

## Requirements
- R1: After reset `busy_o`, `stall_o` and `wb_vld_o` are 0 and `stage_o` is 0 (idle).
- R2: `stage_o` uses this encoding: 0 idle, 1 DF, 2 E1, 3 ED, 4 E2, 5 SF. The cycle that accepts a single-precision issue (`prec_i`=0) counts as fetch. The 12 cycles after it show DF, E1, ED seven times, E1, E2 and SF. The block is then idle.
- R3: The 25 cycles after an accepted double-precision issue (`prec_i`=1) show DF, E1 twice, ED seventeen times, E1 three times, E2 and SF. The block is then idle.
- R4: The stage sequence advances one step every cycle even while `stall_o` is held high, so completion time does not depend on stalls.
- R5: While busy and not in SF, a valid next instruction whose source or destination index equals the pending destination gets `stall_o`=1.
- R6: A valid next instruction with both indices different from the pending destination and `nxt_fpu_ctl_i`=0 gets `stall_o`=0 while the square root is running.
- R7: A valid next instruction with `nxt_fpu_ctl_i`=1 is stalled while busy and not in SF, whatever its indices are.
- R8: In the SF cycle `wb_vld_o` is 1 for exactly one cycle, `wb_idx_o` equals the issued destination, and `stall_o` is 0.
- R9: An issue while busy and not in SF is held (`stall_o`=1) and not accepted. An issue held in the SF cycle is accepted, and `stage_o` shows DF on the next cycle.
- R10: When idle, `stall_o` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| iss_vld_i | input | 1 | Square-root issue request |
| prec_i | input | 1 | 0 single, 1 double precision |
| iss_dst_i | input | 4 | Destination register index of the issue |
| nxt_vld_i | input | 1 | Next instruction valid |
| nxt_src_i | input | 4 | Next instruction source index |
| nxt_dst_i | input | 4 | Next instruction destination index |
| nxt_fpu_ctl_i | input | 1 | Next instruction uses floating-point state |
| stall_o | output | 1 | Hold the next instruction or issue |
| busy_o | output | 1 | Square root in flight |
| stage_o | output | 3 | Current stage code |
| wb_vld_o | output | 1 | Write-back pulse |
| wb_idx_o | output | 4 | Write-back destination index |

## Verification
A wrong stage counter or profile boundary shows on `stage_o` in the first cycle it affects. It also moves the `wb_vld_o` pulse away from cycle 12 or 25 after issue. A busy flag or stored destination that is corrupted appears as a stall that is missing or spurious on the very cycle the next instruction is presented. A late release shows as `stall_o` still high in the SF cycle. Holding a dependent instruction for a full sequence and checking that write-back still lands on time exposes any coupling between the stall and the iterative stages.

// File: rtl/sqrt_seq_pkg.sv
package sqrt_seq_pkg;
  typedef enum logic [2:0] {
    STG_IDLE = 3'd0,
    STG_DF   = 3'd1,
    STG_E1   = 3'd2,
    STG_ED   = 3'd3,
    STG_E2   = 3'd4,
    STG_SF   = 3'd5
  } stg_e;

  // stages outside the variable runs: fetch, DF, E2, SF
  localparam int FIXED_STAGES = 4;
endpackage

// File: rtl/sqrt_stage_map.sv
module sqrt_stage_map
  import sqrt_seq_pkg::*;
#(
  parameter int LEAD_E1 = 1,
  parameter int ITER_ED = 7,
  parameter int TAIL_E1 = 1,
  parameter int CNT_W   = 5
) (
  input  logic [CNT_W-1:0] cnt_i,
  output stg_e             stage_o
);
  // count 1 is DF; each following region starts where the previous ends
  localparam int P_LEAD = 2;
  localparam int P_ITER = P_LEAD + LEAD_E1;
  localparam int P_TAIL = P_ITER + ITER_ED;
  localparam int P_E2   = P_TAIL + TAIL_E1;
  localparam int P_SF   = P_E2 + 1;

  always_comb begin
    if (int'(cnt_i) == 0)
      stage_o = STG_IDLE;
    else if (int'(cnt_i) < P_LEAD)
      stage_o = STG_DF;
    else if (int'(cnt_i) < P_ITER)
      stage_o = STG_E1;
    else if (int'(cnt_i) < P_TAIL)
      stage_o = STG_ED;
    else if (int'(cnt_i) < P_E2)
      stage_o = STG_E1;
    else if (int'(cnt_i) < P_SF)
      stage_o = STG_E2;
    else if (int'(cnt_i) == P_SF)
      stage_o = STG_SF;
    else
      stage_o = STG_IDLE;
  end
endmodule

// File: rtl/sqrt_seq_core.sv
module sqrt_seq_core #(
  parameter int CNT_W   = 5,
  parameter int IDX_W   = 4,
  parameter int SP_LAST = 12,
  parameter int DP_LAST = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept_i,
  input  logic             prec_i,
  input  logic [IDX_W-1:0] dst_i,
  output logic             busy_o,
  output logic             prec_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [IDX_W-1:0] dst_o
);
  localparam logic [CNT_W-1:0] SP_END = CNT_W'(SP_LAST);
  localparam logic [CNT_W-1:0] DP_END = CNT_W'(DP_LAST);
  localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);

  logic             busy_q, busy_d;
  logic             prec_q, prec_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [IDX_W-1:0] dst_q, dst_d;
  logic             at_end;
  logic             seq_en;

  assign at_end = busy_q && (cnt_q == (prec_q ? DP_END : SP_END));
  assign seq_en = accept_i | busy_q;

  always_comb begin
    busy_d = busy_q;
    prec_d = prec_q;
    cnt_d  = cnt_q;
    dst_d  = dst_q;
    if (accept_i) begin
      busy_d = 1'b1;
      prec_d = prec_i;
      cnt_d  = ONE;
      dst_d  = dst_i;
    end else if (at_end) begin
      busy_d = 1'b0;
      cnt_d  = '0;
    end else if (busy_q) begin
      cnt_d  = cnt_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      prec_q <= 1'b0;
      cnt_q  <= '0;
      dst_q  <= '0;
    end else if (seq_en) begin
      busy_q <= busy_d;
      prec_q <= prec_d;
      cnt_q  <= cnt_d;
      dst_q  <= dst_d;
    end
  end

  assign busy_o = busy_q;
  assign prec_o = prec_q;
  assign cnt_o  = cnt_q;
  assign dst_o  = dst_q;
endmodule

// File: rtl/sqrt_hazard.sv
module sqrt_hazard #(
  parameter int IDX_W = 4
) (
  input  logic             busy_i,
  input  logic             in_sf_i,
  input  logic [IDX_W-1:0] pend_dst_i,
  input  logic             iss_vld_i,
  input  logic             nxt_vld_i,
  input  logic [IDX_W-1:0] nxt_src_i,
  input  logic [IDX_W-1:0] nxt_dst_i,
  input  logic             nxt_fpu_ctl_i,
  output logic             accept_o,
  output logic             stall_o
);
  logic hold_win;
  logic dep_hit;

  // the hold window covers every busy cycle except the final one
  assign hold_win = busy_i && !in_sf_i;
  assign dep_hit  = nxt_vld_i &&
                    (nxt_fpu_ctl_i || (nxt_src_i == pend_dst_i) ||
                     (nxt_dst_i == pend_dst_i));
  assign stall_o  = hold_win && (dep_hit || iss_vld_i);
  assign accept_o = iss_vld_i && !hold_win;
endmodule

// File: rtl/sqrt_seq_ctrl.sv
module sqrt_seq_ctrl
  import sqrt_seq_pkg::*;
#(
  parameter int IDX_W      = 4,
  parameter int SP_LEAD_E1 = 1,
  parameter int SP_ITER_ED = 7,
  parameter int SP_TAIL_E1 = 1,
  parameter int DP_LEAD_E1 = 2,
  parameter int DP_ITER_ED = 17,
  parameter int DP_TAIL_E1 = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             iss_vld_i,
  input  logic             prec_i,
  input  logic [IDX_W-1:0] iss_dst_i,
  input  logic             nxt_vld_i,
  input  logic [IDX_W-1:0] nxt_src_i,
  input  logic [IDX_W-1:0] nxt_dst_i,
  input  logic             nxt_fpu_ctl_i,
  output logic             stall_o,
  output logic             busy_o,
  output logic [2:0]       stage_o,
  output logic             wb_vld_o,
  output logic [IDX_W-1:0] wb_idx_o
);
  localparam int SP_LEN  = FIXED_STAGES + SP_LEAD_E1 + SP_ITER_ED + SP_TAIL_E1;
  localparam int DP_LEN  = FIXED_STAGES + DP_LEAD_E1 + DP_ITER_ED + DP_TAIL_E1;
  localparam int MAX_LEN = (SP_LEN > DP_LEN) ? SP_LEN : DP_LEN;
  localparam int CNT_W   = $clog2(MAX_LEN);

  // reset: asserted at once, released two edges later
  logic [1:0] rsync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  logic             busy;
  logic             prec_q;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] pend_dst;
  logic             accept;
  logic             in_sf;
  stg_e             prof_stage [2];
  stg_e             cur_stage;

  sqrt_seq_core #(
    .CNT_W  (CNT_W),
    .IDX_W  (IDX_W),
    .SP_LAST(SP_LEN - 1),
    .DP_LAST(DP_LEN - 1)
  ) u_core (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .accept_i(accept),
    .prec_i  (prec_i),
    .dst_i   (iss_dst_i),
    .busy_o  (busy),
    .prec_o  (prec_q),
    .cnt_o   (cnt),
    .dst_o   (pend_dst)
  );

  // one stage map per precision profile
  for (genvar p = 0; p < 2; p++) begin : g_prof
    localparam int LEAD = (p == 0) ? SP_LEAD_E1 : DP_LEAD_E1;
    localparam int ITER = (p == 0) ? SP_ITER_ED : DP_ITER_ED;
    localparam int TAIL = (p == 0) ? SP_TAIL_E1 : DP_TAIL_E1;
    sqrt_stage_map #(
      .LEAD_E1(LEAD),
      .ITER_ED(ITER),
      .TAIL_E1(TAIL),
      .CNT_W  (CNT_W)
    ) u_map (
      .cnt_i  (cnt),
      .stage_o(prof_stage[p])
    );
  end

  assign cur_stage = busy ? prof_stage[prec_q] : STG_IDLE;
  assign in_sf     = (cur_stage == STG_SF);

  sqrt_hazard #(
    .IDX_W(IDX_W)
  ) u_haz (
    .busy_i       (busy),
    .in_sf_i      (in_sf),
    .pend_dst_i   (pend_dst),
    .iss_vld_i    (iss_vld_i),
    .nxt_vld_i    (nxt_vld_i),
    .nxt_src_i    (nxt_src_i),
    .nxt_dst_i    (nxt_dst_i),
    .nxt_fpu_ctl_i(nxt_fpu_ctl_i),
    .accept_o     (accept),
    .stall_o      (stall_o)
  );

  assign busy_o   = busy;
  assign stage_o  = cur_stage;
  assign wb_vld_o = in_sf;
  assign wb_idx_o = in_sf ? pend_dst : '0;
endmodule

// File: rtl/sqrt_seq_chk.sv
module sqrt_seq_chk #(
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_int_n,
  input logic             iss_vld_i,
  input logic             nxt_vld_i,
  input logic [IDX_W-1:0] nxt_src_i,
  input logic [IDX_W-1:0] nxt_dst_i,
  input logic             nxt_fpu_ctl_i,
  input logic [IDX_W-1:0] pend_dst,
  input logic             stall_o,
  input logic             busy_o,
  input logic [2:0]       stage_o,
  input logic             wb_vld_o
);
  localparam logic [2:0] C_IDLE = 3'd0;
  localparam logic [2:0] C_DF   = 3'd1;
  localparam logic [2:0] C_SF   = 3'd5;

  // R1 / R10: idle means no hold
  a_r10_idle_no_stall: assert property (@(posedge clk) disable iff (!rst_int_n)
    !busy_o |-> !stall_o);

  a_r1_idle_stage: assert property (@(posedge clk) disable iff (!rst_int_n)
    !busy_o |-> (stage_o == C_IDLE));

  // R4: a running sequence never drops out before SF
  a_r4_keeps_running: assert property (@(posedge clk) disable iff (!rst_int_n)
    (busy_o && stage_o != C_SF) |=> busy_o);

  // R5: result register dependence held
  a_r5_dep_hold: assert property (@(posedge clk) disable iff (!rst_int_n)
    (busy_o && stage_o != C_SF && nxt_vld_i &&
     (nxt_src_i == pend_dst || nxt_dst_i == pend_dst)) |-> stall_o);

  // R6: unrelated instruction flows
  a_r6_indep_flow: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!iss_vld_i && nxt_vld_i && !nxt_fpu_ctl_i &&
     nxt_src_i != pend_dst && nxt_dst_i != pend_dst) |-> !stall_o);

  // R7: floating-point state users held
  a_r7_fpu_ctl_hold: assert property (@(posedge clk) disable iff (!rst_int_n)
    (busy_o && stage_o != C_SF && nxt_vld_i && nxt_fpu_ctl_i) |-> stall_o);

  // R8: release and one-cycle write-back
  a_r8_sf_release: assert property (@(posedge clk) disable iff (!rst_int_n)
    (stage_o == C_SF) |-> !stall_o);

  a_r8_wb_single: assert property (@(posedge clk) disable iff (!rst_int_n)
    wb_vld_o |=> !wb_vld_o);

  // R9: issue held in SF restarts at DF
  a_r9_restart: assert property (@(posedge clk) disable iff (!rst_int_n)
    (stage_o == C_SF && iss_vld_i) |=> (stage_o == C_DF));
endmodule

bind sqrt_seq_ctrl sqrt_seq_chk #(.IDX_W(IDX_W)) u_chk (
  .clk          (clk),
  .rst_int_n    (rst_int_n),
  .iss_vld_i    (iss_vld_i),
  .nxt_vld_i    (nxt_vld_i),
  .nxt_src_i    (nxt_src_i),
  .nxt_dst_i    (nxt_dst_i),
  .nxt_fpu_ctl_i(nxt_fpu_ctl_i),
  .pend_dst     (pend_dst),
  .stall_o      (stall_o),
  .busy_o       (busy_o),
  .stage_o      (stage_o),
  .wb_vld_o     (wb_vld_o)
);

// File: tb/sim_sqrt_seq_ctrl.sv
`timescale 1ns/1ps
module sim_sqrt_seq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       iss_vld_i, prec_i;
  logic [3:0] iss_dst_i;
  logic       nxt_vld_i;
  logic [3:0] nxt_src_i, nxt_dst_i;
  logic       nxt_fpu_ctl_i;
  logic       stall_o, busy_o, wb_vld_o;
  logic [2:0] stage_o;
  logic [3:0] wb_idx_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  sqrt_seq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .iss_vld_i(iss_vld_i), .prec_i(prec_i),
    .iss_dst_i(iss_dst_i), .nxt_vld_i(nxt_vld_i), .nxt_src_i(nxt_src_i),
    .nxt_dst_i(nxt_dst_i), .nxt_fpu_ctl_i(nxt_fpu_ctl_i), .stall_o(stall_o),
    .busy_o(busy_o), .stage_o(stage_o), .wb_vld_o(wb_vld_o), .wb_idx_o(wb_idx_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // expected stage code for step k (1-based) of a profile
  function automatic int exp_stage(input bit dp, input int k);
    int lead, iter, tail;
    lead = dp ? 2 : 1;
    iter = dp ? 17 : 7;
    tail = dp ? 3 : 1;
    if (k == 1) return 1;
    if (k < 2 + lead) return 2;
    if (k < 2 + lead + iter) return 3;
    if (k < 2 + lead + iter + tail) return 2;
    if (k == 2 + lead + iter + tail) return 4;
    return 5;
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic idle_inputs();
    iss_vld_i = 0; prec_i = 0; iss_dst_i = 0;
    nxt_vld_i = 0; nxt_src_i = 0; nxt_dst_i = 0; nxt_fpu_ctl_i = 0;
  endtask

  // drives an issue at a negedge; returns at the negedge after the accepting edge
  task automatic issue(input bit dp, input logic [3:0] dst);
    iss_vld_i = 1; prec_i = dp; iss_dst_i = dst;
    #1;
    chk(stall_o == 0, "R10", stall_o, 0);
    tick();
    iss_vld_i = 0;
  endtask

  task automatic t_reset();
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) tick();
    chk(busy_o == 0, "R1 busy", busy_o, 0);
    chk(stage_o == 0, "R1 stage", stage_o, 0);
    chk(stall_o == 0, "R1 stall", stall_o, 0);
    chk(wb_vld_o == 0, "R1 wb", wb_vld_o, 0);
  endtask

  task automatic t_sequence(input bit dp, input logic [3:0] dst);
    int last;
    last = dp ? 25 : 12;
    issue(dp, dst);
    for (int k = 1; k <= last; k++) begin
      chk(int'(stage_o) == exp_stage(dp, k), dp ? "R3 stage" : "R2 stage",
          stage_o, exp_stage(dp, k));
      chk(wb_vld_o == (k == last), "R8 wb timing", wb_vld_o, k == last);
      if (k == last) chk(wb_idx_o == dst, "R8 wb idx", wb_idx_o, dst);
      if (k != last) tick();
    end
    tick();
    chk(busy_o == 0 && stage_o == 0, dp ? "R3 end" : "R2 end", stage_o, 0);
    chk(wb_vld_o == 0, "R8 pulse width", wb_vld_o, 0);
  endtask

  // dependent held all the way; completion time unchanged
  task automatic t_dep_hold();
    issue(1'b0, 4'd3);
    nxt_vld_i = 1; nxt_src_i = 4'd3; nxt_dst_i = 4'd8; nxt_fpu_ctl_i = 0;
    for (int k = 1; k <= 12; k++) begin
      #0;
      if (k < 12) chk(stall_o == 1, "R5 src hold", stall_o, 1);
      else begin
        chk(stall_o == 0, "R8 release", stall_o, 0);
        chk(wb_vld_o == 1, "R4 wb on time", wb_vld_o, 1);
      end
      if (k < 12) tick();
    end
    tick();
    chk(stall_o == 0, "R10 after", stall_o, 0);
    nxt_vld_i = 0;
  endtask

  task automatic t_mix();
    issue(1'b1, 4'd6);
    nxt_vld_i = 1; nxt_src_i = 4'd4; nxt_dst_i = 4'd7; nxt_fpu_ctl_i = 0;
    #1; chk(stall_o == 0, "R6 indep", stall_o, 0);
    tick();
    nxt_src_i = 4'd1; nxt_dst_i = 4'd6;
    #1; chk(stall_o == 1, "R5 dst hold", stall_o, 1);
    tick();
    nxt_dst_i = 4'd2; nxt_fpu_ctl_i = 1;
    #1; chk(stall_o == 1, "R7 fpu ctl", stall_o, 1);
    tick();
    nxt_fpu_ctl_i = 0;
    #1; chk(stall_o == 0, "R6 indep late", stall_o, 0);
    nxt_vld_i = 0;
    while (busy_o) tick();
  endtask

  task automatic t_second();
    issue(1'b0, 4'd10);
    iss_vld_i = 1; prec_i = 1; iss_dst_i = 4'd12;
    for (int k = 1; k < 12; k++) begin
      #0;
      chk(stall_o == 1, "R9 held", stall_o, 1);
      tick();
    end
    chk(stage_o == 5 && stall_o == 0, "R9 sf accept", stall_o, 0);
    chk(wb_idx_o == 4'd10, "R8 first idx", wb_idx_o, 10);
    tick();
    iss_vld_i = 0;
    chk(stage_o == 1, "R9 restart DF", stage_o, 1);
    repeat (24) tick();
    chk(wb_vld_o == 1 && wb_idx_o == 4'd12, "R9 second wb", wb_idx_o, 12);
    tick();
    chk(busy_o == 0, "R3 done", busy_o, 0);
  endtask

  initial begin
    t_reset();
    t_sequence(1'b0, 4'd5);
    t_sequence(1'b1, 4'd9);
    t_dep_hold();
    t_mix();
    t_second();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #80000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule